// File: doc/BRIEF.md
# Paged Serial Flash Range Eraser

This block erases a byte range of a page-organised serial flash through a byte-level SPI shifter. A requester presents a start offset and a length, both in bytes, on a one-cycle `req_valid` strobe. The block turns both into whole page counts with a pair of sequential dividers. If either value leaves a remainder, it finishes at once with a misalignment code and sends no SPI traffic. Otherwise it walks the range in steps. At each step it issues one four-byte erase command, then polls the device status until the device reports ready. The page size need not be a power of two.

Each step uses an eight-page block erase when the current page number is a multiple of eight and at least eight pages remain. Otherwise it uses a single-page erase. The device address is the page number shifted left by a fixed, device-dependent amount. Status polls are a two-byte exchange. Consecutive polls are separated by a programmable number of cycles, and a programmable cycle budget bounds the wait after each command. The block ends every request with a single `done` pulse and a result code.

Top module: `flash_erase_seq`

## Requirements
- R1: If the offset or the length is not a whole multiple of PAGE_BYTES, the block pulses `done` with `err_code` = 1 and keeps `spi_cs_n` high for the whole request.
- R2: A step uses opcode 0x50 when the current page number has its three low bits at zero and at least eight pages remain. Any other step uses opcode 0x81.
- R3: The erase command bytes, in order, are the opcode, device address bits 23:16, device address bits 15:8, and 0x00. The device address is the page number shifted left by PAGE_SHIFT.
- R4: `spi_cs_n` stays low across all four bytes of a command and across both bytes of a status read. It is high between any two such transactions.
- R5: A status read sends 0xD7 and then 0x00. The byte returned for the second one is the status, and status bit 7 set means ready. After each command the block polls until it sees ready, leaving at least POLL_GAP cycles with `spi_cs_n` high between two polls.
- R6: A status byte returned with `spi_xfer_err` set is treated as not ready, whatever its value.
- R7: If a poll reads not-ready once TIMEOUT_CYC cycles have passed since the end of the command, the block pulses `done` with `err_code` = 2 and issues no further command.
- R8: After a ready block erase, the page number advances and the remaining count drops by eight. After a ready page erase, both move by one. When no pages remain, `done` pulses with `err_code` = 0. A zero length finishes this way with no SPI traffic.
- R9: `done` is a single-cycle pulse and there is exactly one per accepted request. `busy` is high from the cycle after acceptance until `done`, and `req_valid` has no effect while `busy` is high.
- R10: While `spi_xfer_req` is high and the shifter has not yet acknowledged with `spi_xfer_done`, `spi_xfer_tx` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Start strobe, taken only while idle |
| req_offset | input | ADDR_W | Start offset in bytes |
| req_len | input | ADDR_W | Length in bytes |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | Result: 0 none, 1 misaligned, 2 timeout |
| spi_cs_n | output | 1 | Device chip select, active low |
| spi_xfer_req | output | 1 | Byte exchange request to the shifter |
| spi_xfer_tx | output | 8 | Byte to send |
| spi_xfer_done | input | 1 | Shifter finished the current byte (one-cycle pulse) |
| spi_xfer_rx | input | 8 | Byte received during the finished exchange |
| spi_xfer_err | input | 1 | The finished exchange failed |

## Verification
The hardest case to reach from the ports is a status byte that carries a failure flag but whose value would otherwise read as ready. The bench's shifter model returns 0xFF with the error line raised on the first poll after every command. A design that ignored the flag would then advance one poll early, which shows up in the poll count. The timeout path is reached the same way: the model keeps the device busy far beyond the bench's small cycle budget. Mixed block and page walks come from ranges that start off a multiple of eight pages, or that end short of a full block.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIV,
        ST_STEP,
        ST_CMD,
        ST_WAIT,
        ST_POLL_OP,
        ST_POLL_RD
    } seq_state_e;

    typedef enum logic [1:0] {
        RES_OK       = 2'd0,
        RES_MISALIGN = 2'd1,
        RES_TIMEOUT  = 2'd2
    } result_e;

    typedef enum logic [1:0] {
        XK_BLOCK,
        XK_PAGE,
        XK_STAT_OP,
        XK_STAT_RD
    } xfer_kind_e;

    localparam logic [7:0] OPC_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OPC_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OPC_STATUS      = 8'hD7;
    localparam int         PAGES_PER_BLOCK = 8;
    localparam int         CMD_BYTES       = 4;
    localparam int         READY_BIT       = 7;

endpackage

// File: rtl/flash_erase_div.sv
module flash_erase_div #(
    parameter int W       = 24,
    parameter int DIVISOR = 264
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         done_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]     acc;
        logic [W-1:0]     quo;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             done;
    } div_regs_t;

    div_regs_t d, q;
    logic [W:0] trial;
    logic       ge;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        trial  = {q.acc, q.quo[W-1]};
        ge     = (trial >= (W+1)'(DIVISOR));
        if (start_i) begin
            d.acc = '0;
            d.quo = dividend_i;
            d.cnt = CNT_W'(W);
            d.run = 1'b1;
        end else if (q.run) begin
            d.acc = ge ? W'(trial - (W+1)'(DIVISOR)) : trial[W-1:0];
            d.quo = {q.quo[W-2:0], ge};
            d.cnt = q.cnt - 1'b1;
            if (q.cnt == CNT_W'(1)) begin
                d.run  = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign quot_o = q.quo;
    assign rem_o  = q.acc;
    assign done_o = q.done;

endmodule

// File: rtl/flash_erase_cmd.sv
module flash_erase_cmd
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 9
) (
    input  xfer_kind_e        kind_i,
    input  logic [ADDR_W-1:0] page_i,
    input  logic [1:0]        idx_i,
    output logic [7:0]        byte_o
);
    localparam int WIDE_W = ADDR_W + PAGE_SHIFT;

    logic [WIDE_W-1:0] wide_addr;
    logic [23:0]       dev_addr;
    logic [7:0]        opcode;

    assign wide_addr = {page_i, {PAGE_SHIFT{1'b0}}};
    assign dev_addr  = wide_addr[23:0];

    always_comb begin
        opcode = (kind_i == XK_BLOCK) ? OPC_BLOCK_ERASE : OPC_PAGE_ERASE;
        unique case (kind_i)
            XK_BLOCK, XK_PAGE: begin
                unique case (idx_i)
                    2'd0:    byte_o = opcode;
                    2'd1:    byte_o = dev_addr[23:16];
                    2'd2:    byte_o = dev_addr[15:8];
                    default: byte_o = 8'h00;
                endcase
            end
            XK_STAT_OP: byte_o = OPC_STATUS;
            default:    byte_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_erase_pkg::*;
#(
    parameter int ADDR_W      = 24,
    parameter int PAGE_BYTES  = 264,
    parameter int PAGE_SHIFT  = 9,
    parameter int TIMEOUT_CYC = 500_000_000,
    parameter int POLL_GAP    = 750_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [ADDR_W-1:0] req_len,
    output logic              busy,
    output logic              done,
    output logic [1:0]        err_code,
    output logic              spi_cs_n,
    output logic              spi_xfer_req,
    output logic [7:0]        spi_xfer_tx,
    input  logic              spi_xfer_done,
    input  logic [7:0]        spi_xfer_rx,
    input  logic              spi_xfer_err
);
    localparam int TMO_W  = $clog2(TIMEOUT_CYC + 1);
    localparam int GAP_W  = $clog2(POLL_GAP + 1);
    localparam int N_DIV  = 2;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] page;
        logic [ADDR_W-1:0] left;
        logic              blk;
        logic [1:0]        idx;
        logic [TMO_W-1:0]  tmo;
        logic [GAP_W-1:0]  gap;
        logic              done;
        result_e           res;
    } seq_regs_t;

    seq_regs_t d, q;

    // Page conversion of offset (0) and length (1)
    logic [ADDR_W-1:0] div_in   [N_DIV];
    logic [ADDR_W-1:0] div_quot [N_DIV];
    logic [ADDR_W-1:0] div_rem  [N_DIV];
    logic              div_done [N_DIV];
    logic              div_start;

    assign div_in[0] = req_offset;
    assign div_in[1] = req_len;
    assign div_start = (q.st == ST_IDLE) && req_valid;

    for (genvar g = 0; g < N_DIV; g++) begin : g_div
        flash_erase_div #(
            .W       (ADDR_W),
            .DIVISOR (PAGE_BYTES)
        ) u_div (
            .clk        (clk),
            .rst_n      (rst_n),
            .start_i    (div_start),
            .dividend_i (div_in[g]),
            .quot_o     (div_quot[g]),
            .rem_o      (div_rem[g]),
            .done_o     (div_done[g])
        );
    end

    // Byte selection
    xfer_kind_e kind;
    logic [7:0] tx_byte;
    logic       in_xfer;
    logic       stat_ready;

    always_comb begin
        unique case (q.st)
            ST_CMD:     kind = q.blk ? XK_BLOCK : XK_PAGE;
            ST_POLL_OP: kind = XK_STAT_OP;
            default:    kind = XK_STAT_RD;
        endcase
    end

    flash_erase_cmd #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_cmd (
        .kind_i (kind),
        .page_i (q.page),
        .idx_i  (q.idx),
        .byte_o (tx_byte)
    );

    assign in_xfer    = (q.st == ST_CMD) || (q.st == ST_POLL_OP) || (q.st == ST_POLL_RD);
    assign stat_ready = spi_xfer_rx[READY_BIT] && !spi_xfer_err;

    // Next-state logic
    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (in_xfer && (q.st != ST_CMD) && (q.tmo != '1)) begin
            d.tmo = q.tmo + 1'b1;
        end
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) d.st = ST_DIV;
            end
            ST_DIV: begin
                if (div_done[0] && div_done[1]) begin
                    if ((div_rem[0] != '0) || (div_rem[1] != '0)) begin
                        d.done = 1'b1;
                        d.res  = RES_MISALIGN;
                        d.st   = ST_IDLE;
                    end else begin
                        d.page = div_quot[0];
                        d.left = div_quot[1];
                        d.st   = ST_STEP;
                    end
                end
            end
            ST_STEP: begin
                if (q.left == '0) begin
                    d.done = 1'b1;
                    d.res  = RES_OK;
                    d.st   = ST_IDLE;
                end else begin
                    d.blk = (q.page[2:0] == 3'd0) &&
                            (q.left >= ADDR_W'(PAGES_PER_BLOCK));
                    d.idx = 2'd0;
                    d.st  = ST_CMD;
                end
            end
            ST_CMD: begin
                if (spi_xfer_done) begin
                    if (q.idx == 2'(CMD_BYTES - 1)) begin
                        d.st  = ST_WAIT;
                        d.gap = '0;
                        d.tmo = '0;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            ST_WAIT: begin
                if (q.tmo != '1) d.tmo = q.tmo + 1'b1;
                if (q.gap == '0) d.st  = ST_POLL_OP;
                else             d.gap = q.gap - 1'b1;
            end
            ST_POLL_OP: begin
                if (spi_xfer_done) d.st = ST_POLL_RD;
            end
            ST_POLL_RD: begin
                if (spi_xfer_done) begin
                    if (stat_ready) begin
                        if (q.blk) begin
                            d.page = q.page + ADDR_W'(PAGES_PER_BLOCK);
                            d.left = q.left - ADDR_W'(PAGES_PER_BLOCK);
                        end else begin
                            d.page = q.page + 1'b1;
                            d.left = q.left - 1'b1;
                        end
                        d.st = ST_STEP;
                    end else if (q.tmo >= TMO_W'(TIMEOUT_CYC)) begin
                        d.done = 1'b1;
                        d.res  = RES_TIMEOUT;
                        d.st   = ST_IDLE;
                    end else begin
                        d.gap = GAP_W'(POLL_GAP);
                        d.st  = ST_WAIT;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.res <= RES_OK;
        end else begin
            q <= d;
        end
    end

    assign busy         = (q.st != ST_IDLE);
    assign done         = q.done;
    assign err_code     = q.res;
    assign spi_cs_n     = !in_xfer;
    assign spi_xfer_req = in_xfer;
    assign spi_xfer_tx  = tx_byte;

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic [1:0] err_code,
    input logic       spi_cs_n,
    input logic       spi_xfer_req,
    input logic [7:0] spi_xfer_tx,
    input logic       spi_xfer_done
);
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code != 2'd3));

    assert_tx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_xfer_req && !spi_xfer_done) |=> (spi_xfer_req && $stable(spi_xfer_tx)));

    assert_cs_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_cs_n) |-> $past(spi_xfer_done));

endmodule

bind flash_erase_seq flash_erase_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .busy          (busy),
    .done          (done),
    .err_code      (err_code),
    .spi_cs_n      (spi_cs_n),
    .spi_xfer_req  (spi_xfer_req),
    .spi_xfer_tx   (spi_xfer_tx),
    .spi_xfer_done (spi_xfer_done)
);

// File: tb/sim_flash_erase_seq.sv
module sim_flash_erase_seq;
    localparam int PB   = 264;
    localparam int PS   = 9;
    localparam int TMO  = 400;
    localparam int GAP  = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_offset = '0;
    logic [23:0] req_len = '0;
    logic        busy, done, spi_cs_n, spi_xfer_req;
    logic [1:0]  err_code;
    logic [7:0]  spi_xfer_tx;
    logic        spi_xfer_done = 1'b0;
    logic [7:0]  spi_xfer_rx = '0;
    logic        spi_xfer_err = 1'b0;

    always #2 clk = ~clk;

    flash_erase_seq #(
        .ADDR_W(24), .PAGE_BYTES(PB), .PAGE_SHIFT(PS),
        .TIMEOUT_CYC(TMO), .POLL_GAP(GAP)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_offset(req_offset), .req_len(req_len),
        .busy(busy), .done(done), .err_code(err_code),
        .spi_cs_n(spi_cs_n), .spi_xfer_req(spi_xfer_req),
        .spi_xfer_tx(spi_xfer_tx), .spi_xfer_done(spi_xfer_done),
        .spi_xfer_rx(spi_xfer_rx), .spi_xfer_err(spi_xfer_err)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Shifter / device model, running on the falling edge
    int        busy_polls = 0;
    bit        inject_err = 0;
    logic [7:0] log_b [0:63][0:3];
    int        n_cmd, n_stat, bad_sess, polls_cmd, gap_ctr, min_gap, any_traffic;
    bit        prev_notready, sess_open, sess_stat, m_active;
    int        m_pos, m_cnt;
    logic [7:0] m_byte, sess_b [0:3];
    int        done_cnt;
    logic [1:0] last_err;

    task automatic clear_model();
        n_cmd = 0; n_stat = 0; bad_sess = 0; polls_cmd = 0;
        gap_ctr = 0; min_gap = 1000000; prev_notready = 0;
        done_cnt = 0; any_traffic = 0;
    endtask

    always @(negedge clk) begin
        spi_xfer_done <= 1'b0;
        if (done) begin done_cnt++; last_err = err_code; end
        if (!spi_cs_n) any_traffic++;
        if (spi_cs_n) begin
            if (sess_open) begin
                if (sess_stat) begin
                    if (m_pos != 2) bad_sess++;
                    gap_ctr = 0;
                end else begin
                    if (m_pos != 4) bad_sess++;
                    if (n_cmd < 64) for (int k = 0; k < 4; k++) log_b[n_cmd][k] = sess_b[k];
                    n_cmd++;
                    polls_cmd = 0;
                    prev_notready = 0;
                end
                sess_open = 0;
            end
            m_pos = 0;
            gap_ctr++;
        end
        if (m_active) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_active = 0;
                if (m_pos == 0) begin
                    sess_open = 1;
                    sess_stat = (m_byte == 8'hD7);
                    if (sess_stat) begin
                        n_stat++;
                        if (prev_notready && gap_ctr < min_gap) min_gap = gap_ctr;
                    end
                end
                if (m_pos < 4) sess_b[m_pos] = m_byte;
                m_pos++;
                if (sess_stat && m_pos == 2) begin
                    polls_cmd++;
                    if (inject_err && polls_cmd == 1) begin
                        spi_xfer_rx <= 8'hFF; spi_xfer_err <= 1'b1; prev_notready = 1;
                    end else if (polls_cmd > busy_polls) begin
                        spi_xfer_rx <= 8'h81; spi_xfer_err <= 1'b0; prev_notready = 0;
                    end else begin
                        spi_xfer_rx <= 8'h01; spi_xfer_err <= 1'b0; prev_notready = 1;
                    end
                end else begin
                    spi_xfer_rx <= 8'h00; spi_xfer_err <= 1'b0;
                end
                spi_xfer_done <= 1'b1;
            end
        end else if (spi_xfer_req && !spi_xfer_done && !spi_cs_n) begin
            m_active = 1; m_cnt = 3; m_byte = spi_xfer_tx;
        end
    end

    task automatic pulse_req(input int off, input int len);
        @(negedge clk);
        req_offset = 24'(off); req_len = 24'(len); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done();
        int lim = 0;
        while (done_cnt == 0 && lim < 40000) begin @(negedge clk); lim++; end
        repeat (40) @(negedge clk);
    endtask

    // Compare logged commands against an independent walk of the range
    task automatic check_walk(input int off, input int len, input int exp_err, input int polls_per);
        int pg = off / PB;
        int left = len / PB;
        int n = 0;
        int mism = 0;
        int exp_cmds;
        if (exp_err == 0) begin
            while (left > 0) begin
                bit blk = (pg % 8 == 0) && (left >= 8);
                int a = pg << PS;
                if (n < 64 && n < n_cmd) begin
                    if (log_b[n][0] != (blk ? 8'h50 : 8'h81)) mism++;
                    if (log_b[n][1] != 8'(a >> 16) || log_b[n][2] != 8'(a >> 8) || log_b[n][3] != 8'h00) mism++;
                end
                n++;
                pg += blk ? 8 : 1;
                left -= blk ? 8 : 1;
            end
            exp_cmds = n;
        end else begin
            exp_cmds = (exp_err == 2) ? 1 : 0;
        end
        chk(done_cnt == 1, "R9 done pulses", done_cnt, 1);
        chk(last_err == 2'(exp_err), "R1/R7/R8 result code", int'(last_err), exp_err);
        chk(n_cmd == exp_cmds, "R8 command count", n_cmd, exp_cmds);
        chk(mism == 0, "R2/R3 command bytes", mism, 0);
        chk(bad_sess == 0, "R4 session framing", bad_sess, 0);
        if (exp_err == 0)
            chk(n_stat == exp_cmds * polls_per, "R5 status polls", n_stat, exp_cmds * polls_per);
        if (exp_err == 1)
            chk(any_traffic == 0, "R1 chip select stayed high", any_traffic, 0);
        if (polls_per > 1 && exp_cmds > 0)
            chk(min_gap >= GAP, "R5 poll spacing", min_gap, GAP);
    endtask

    // {offset, length, busy polls, expected result}
    localparam logic [65:0] VEC [0:6] = '{
        {24'd0,        24'd2112, 16'd0, 2'd0},
        {24'd792,      24'd2640, 16'd2, 2'd0},
        {24'd2112,     24'd4488, 16'd1, 2'd0},
        {24'd100,      24'd264,  16'd0, 2'd1},
        {24'd264,      24'd10,   16'd0, 2'd1},
        {24'd0,        24'd0,    16'd0, 2'd0},
        {24'd264000,   24'd2376, 16'd0, 2'd0}
    };

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        clear_model();
        sess_open = 0; m_active = 0; m_pos = 0;
        repeat (4) @(negedge clk);
        // Reset state
        chk(busy == 0 && done == 0, "R9 reset idle", int'(busy), 0);
        chk(spi_cs_n == 1 && spi_xfer_req == 0, "R4 reset chip select", int'(spi_cs_n), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int v = 0; v < 7; v++) begin
            int off = int'(VEC[v][65:42]);
            int len = int'(VEC[v][41:18]);
            int bp  = int'(VEC[v][17:2]);
            int ee  = int'(VEC[v][1:0]);
            clear_model();
            busy_polls = bp; inject_err = 0;
            pulse_req(off, len);
            wait_done();
            check_walk(off, len, ee, bp + 1);
        end

        // R6: failed status read whose byte reads as ready must not advance
        clear_model();
        busy_polls = 0; inject_err = 1;
        pulse_req(0, PB * 9);
        wait_done();
        check_walk(0, PB * 9, 0, 2);
        inject_err = 0;

        // R7: device never ready
        clear_model();
        busy_polls = 100000;
        pulse_req(PB * 16, PB * 8);
        wait_done();
        check_walk(PB * 16, PB * 8, 2, 1);
        chk(busy == 0, "R7 idle after timeout", int'(busy), 0);

        // R9: second request during a busy walk is ignored
        clear_model();
        busy_polls = 3;
        pulse_req(0, PB * 2);
        repeat (10) @(negedge clk);
        chk(busy == 1, "R9 busy during walk", int'(busy), 1);
        pulse_req(PB * 5, PB);
        wait_done();
        check_walk(0, PB * 2, 0, 4);

        summary();
    end

endmodule